// File: doc/BRIEF.md
# Bit-Oriented Message Receiver

This block watches a serial data-link stream, one bit per strobe, for repeating 16-bit message frames. Each frame is a run of eight ones, a zero, a six-bit code (most significant bit first) and a closing zero. The block pulls the code out of every frame it finds. It then votes over the ten most recent frames to decide whether a steady message is present.

A separate window check raises an interrupt when the stream goes 32 bits without a run of eight ones. A second interrupt, which has its own enable, marks the moment a steady message is lost. Dropping the receiver enable clears the whole receiver and holds it idle.

Top module: `bom_rx`

## Requirements
- R1: A frame is found when the last 16 strobed bits are `1111_1111`, `0`, c5..c0, `0` in arrival order. The code c5..c0, with c5 the first received code bit, is driven on `msgCode` as the current candidate.
- R2: `msgValid` rises once at least 7 of the last 10 frames carry the candidate code. Six matching frames are not enough.
- R3: `msgValid` falls when fewer than 7 of the last 10 frames match the candidate. `msgCode` holds its value for as long as `msgValid` stays high.
- R4: When `msgValid` falls while `invIntEnable` is high, `invalidPulse` goes high for exactly one cycle. When `invIntEnable` is low, no pulse is produced.
- R5: `syncErrPulse` goes high for exactly one cycle when 32 strobed bits pass without eight consecutive ones. A run of eight ones restarts the 32-bit window.
- R6: A frame whose code differs from the candidate, arriving while `msgValid` is low, becomes the new candidate with a history of one match.
- R7: While `rxEnable` is low, all state clears, `msgValid` and `msgCode` read 0, and strobed bits are ignored. No interrupt is produced, even for a strobe in the cycle the enable drops.
- R8: After reset, `msgValid`, `msgCode`, `syncErrPulse` and `invalidPulse` are all 0.
- R9: Changes on `bitIn` without `bitStrobe` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Receiver enable; low clears all state |
| invIntEnable | input | 1 | Enables the message-lost interrupt |
| bitIn | input | 1 | Serial data bit |
| bitStrobe | input | 1 | Qualifies `bitIn` for one cycle |
| msgCode | output | 6 | Candidate / decoded message code |
| msgValid | output | 1 | Steady message present |
| syncErrPulse | output | 1 | One-cycle pulse on a missed sync window |
| invalidPulse | output | 1 | One-cycle pulse when a steady message is lost |

## Verification
Two events can land in the same cycle: the enable dropping, and a strobe that would otherwise finish a pulse-raising event. One such strobe is the last bit of a frame that breaks the vote while the message is valid. The other is the 32nd bit of a window with no sync run. The bench lines up each of these final strobes with the falling `rxEnable` edge. It then counts pulses at the ports, expecting none. After re-enabling, it confirms that the history and the window start over from zero.

// File: rtl/bom_rx_pkg.sv
package bom_rx_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic shiftEn;
    logic winClear;
    logic winInc;
    logic loadCand;
    logic pushHist;
    logic histBit;
  } bomCtrl_t;

endpackage

// File: rtl/bom_rx_datapath.sv
module bom_rx_datapath
  import bom_rx_pkg::*;
#(
  parameter int FLAG_LEN = 8,
  parameter int CODE_W   = 6,
  parameter int HIST_LEN = 10,
  parameter int SYNC_WIN = 32,
  localparam int FRAME_W = FLAG_LEN + CODE_W + 2,
  localparam int RUN_W   = $clog2(FLAG_LEN + 1),
  localparam int WIN_W   = $clog2(SYNC_WIN),
  localparam int CNT_W   = $clog2(HIST_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bomCtrl_t          ctrl,
  input  logic              bitIn,
  output logic              frameHit,
  output logic              codeMatch,
  output logic              syncSeen,
  output logic              winAtLast,
  output logic [CNT_W-1:0]  histCount,
  output logic [CODE_W-1:0] candCode,
  output logic              candHeld
);

  logic [FRAME_W-1:0]  shiftQ, nextShift;
  logic [RUN_W-1:0]    onesRunQ;
  logic [WIN_W-1:0]    winQ;
  logic [HIST_LEN-1:0] histQ;
  logic [CODE_W-1:0]   rxCode;
  logic                flagOk;

  assign nextShift = {shiftQ[FRAME_W-2:0], bitIn};
  assign flagOk    = &nextShift[FRAME_W-1:FRAME_W-FLAG_LEN];
  assign frameHit  = flagOk && !nextShift[CODE_W+1] && !nextShift[0];
  assign rxCode    = nextShift[CODE_W:1];
  assign codeMatch = candHeld && (rxCode == candCode);
  assign syncSeen  = bitIn && (onesRunQ >= RUN_W'(FLAG_LEN - 1));
  assign winAtLast = (winQ == WIN_W'(SYNC_WIN - 1));
  assign histCount = CNT_W'($countones(histQ));

  // serial shifter
  always_ff @(posedge clk) begin
    if (!rst_n || ctrl.clearAll)
      shiftQ <= '0;
    else if (ctrl.shiftEn)
      shiftQ <= nextShift;
  end

  // run of ones, saturating at flag length
  always_ff @(posedge clk) begin
    if (!rst_n || ctrl.clearAll)
      onesRunQ <= '0;
    else if (ctrl.shiftEn) begin
      if (!bitIn)
        onesRunQ <= '0;
      else if (onesRunQ != RUN_W'(FLAG_LEN))
        onesRunQ <= onesRunQ + RUN_W'(1);
    end
  end

  // sync window
  always_ff @(posedge clk) begin
    if (!rst_n || ctrl.clearAll || ctrl.winClear)
      winQ <= '0;
    else if (ctrl.winInc)
      winQ <= winQ + WIN_W'(1);
  end

  // vote history, newest in bit 0
  always_ff @(posedge clk) begin
    if (!rst_n || ctrl.clearAll)
      histQ <= '0;
    else if (ctrl.loadCand)
      histQ <= {{(HIST_LEN-1){1'b0}}, 1'b1};
    else if (ctrl.pushHist)
      histQ <= {histQ[HIST_LEN-2:0], ctrl.histBit};
  end

  // candidate code
  always_ff @(posedge clk) begin
    if (!rst_n || ctrl.clearAll) begin
      candCode <= '0;
      candHeld <= 1'b0;
    end else if (ctrl.loadCand) begin
      candCode <= rxCode;
      candHeld <= 1'b1;
    end
  end

endmodule

// File: rtl/bom_rx_control.sv
module bom_rx_control
  import bom_rx_pkg::*;
#(
  parameter int HIST_LEN = 10,
  parameter int VOTE_MIN = 7,
  localparam int CNT_W   = $clog2(HIST_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxEnable,
  input  logic             invIntEnable,
  input  logic             bitStrobe,
  input  logic             frameHit,
  input  logic             codeMatch,
  input  logic             candHeld,
  input  logic             syncSeen,
  input  logic             winAtLast,
  input  logic [CNT_W-1:0] histCount,
  output bomCtrl_t         ctrl,
  output logic             msgValid,
  output logic             syncErrPulse,
  output logic             invalidPulse
);

  logic active, voteMet, validQ, syncErrQ, invalidQ;

  assign active  = rxEnable && bitStrobe;
  assign voteMet = (histCount >= CNT_W'(VOTE_MIN));

  always_comb begin
    ctrl          = '0;
    ctrl.clearAll = !rxEnable;
    if (active) begin
      ctrl.shiftEn = 1'b1;
      if (syncSeen || winAtLast)
        ctrl.winClear = 1'b1;
      else
        ctrl.winInc = 1'b1;
      if (frameHit) begin
        if (!candHeld || (!validQ && !codeMatch))
          ctrl.loadCand = 1'b1;
        else begin
          ctrl.pushHist = 1'b1;
          ctrl.histBit  = codeMatch;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !rxEnable) begin
      validQ   <= 1'b0;
      syncErrQ <= 1'b0;
      invalidQ <= 1'b0;
    end else begin
      validQ   <= voteMet;
      syncErrQ <= active && !syncSeen && winAtLast;
      invalidQ <= validQ && !voteMet && invIntEnable;
    end
  end

  assign msgValid     = validQ;
  assign syncErrPulse = syncErrQ;
  assign invalidPulse = invalidQ;

endmodule

// File: rtl/bom_rx.sv
module bom_rx
  import bom_rx_pkg::*;
#(
  parameter int FLAG_LEN = 8,
  parameter int CODE_W   = 6,
  parameter int HIST_LEN = 10,
  parameter int VOTE_MIN = 7,
  parameter int SYNC_WIN = 32,
  localparam int CNT_W   = $clog2(HIST_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxEnable,
  input  logic              invIntEnable,
  input  logic              bitIn,
  input  logic              bitStrobe,
  output logic [CODE_W-1:0] msgCode,
  output logic              msgValid,
  output logic              syncErrPulse,
  output logic              invalidPulse
);

  bomCtrl_t         ctrl;
  logic             frameHit, codeMatch, syncSeen, winAtLast, candHeld;
  logic [CNT_W-1:0] histCount;

  bom_rx_datapath #(
    .FLAG_LEN(FLAG_LEN), .CODE_W(CODE_W),
    .HIST_LEN(HIST_LEN), .SYNC_WIN(SYNC_WIN)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .bitIn(bitIn),
    .frameHit(frameHit), .codeMatch(codeMatch), .syncSeen(syncSeen),
    .winAtLast(winAtLast), .histCount(histCount),
    .candCode(msgCode), .candHeld(candHeld)
  );

  bom_rx_control #(
    .HIST_LEN(HIST_LEN), .VOTE_MIN(VOTE_MIN)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .rxEnable(rxEnable),
    .invIntEnable(invIntEnable), .bitStrobe(bitStrobe),
    .frameHit(frameHit), .codeMatch(codeMatch), .candHeld(candHeld),
    .syncSeen(syncSeen), .winAtLast(winAtLast), .histCount(histCount),
    .ctrl(ctrl), .msgValid(msgValid), .syncErrPulse(syncErrPulse),
    .invalidPulse(invalidPulse)
  );

endmodule

// File: rtl/bom_rx_checker.sv
module bom_rx_checker #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rxEnable,
  input logic              invIntEnable,
  input logic [CODE_W-1:0] msgCode,
  input logic              msgValid,
  input logic              syncErrPulse,
  input logic              invalidPulse
);

  a_r3_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    (msgValid && $past(msgValid)) |-> $stable(msgCode));

  a_r4_pulse_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    invalidPulse |-> (!msgValid && $past(msgValid)));

  a_r4_pulse_gated: assert property (@(posedge clk) disable iff (!rst_n)
    invalidPulse |-> $past(invIntEnable));

  a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    invalidPulse |=> !invalidPulse);

  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    syncErrPulse |=> !syncErrPulse);

  a_r7_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rxEnable |=> (!msgValid && !syncErrPulse && !invalidPulse && msgCode == '0));

endmodule

bind bom_rx bom_rx_checker #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rxEnable(rxEnable), .invIntEnable(invIntEnable),
  .msgCode(msgCode), .msgValid(msgValid), .syncErrPulse(syncErrPulse),
  .invalidPulse(invalidPulse)
);

// File: tb/bom_rx_test.sv
module bom_rx_test;

  logic       clk = 1'b0;
  logic       rst_n, rxEnable, invIntEnable, bitIn, bitStrobe;
  logic [5:0] msgCode;
  logic       msgValid, syncErrPulse, invalidPulse;

  int checks = 0;
  int errors = 0;
  int syncCnt = 0;
  int invCnt = 0;
  bit finished = 0;

  localparam logic [5:0] CODE_A = 6'h2A;
  localparam logic [5:0] CODE_B = 6'h15;

  always #4 clk = ~clk;

  bom_rx uut (
    .clk(clk), .rst_n(rst_n), .rxEnable(rxEnable), .invIntEnable(invIntEnable),
    .bitIn(bitIn), .bitStrobe(bitStrobe), .msgCode(msgCode),
    .msgValid(msgValid), .syncErrPulse(syncErrPulse), .invalidPulse(invalidPulse)
  );

  always @(negedge clk) begin
    if (syncErrPulse) syncCnt++;
    if (invalidPulse) invCnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk);
    bitIn = b; bitStrobe = 1'b1;
    @(negedge clk);
    bitStrobe = 1'b0;
  endtask

  task automatic sendFrame(input logic [5:0] code);
    for (int i = 0; i < 8; i++) sendBit(1'b1);
    sendBit(1'b0);
    for (int i = 5; i >= 0; i--) sendBit(code[i]);
    sendBit(1'b0);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic clearRx();
    @(negedge clk); rxEnable = 1'b0;
    @(negedge clk); rxEnable = 1'b1;
  endtask

  task automatic testReset();
    check("R8 valid", msgValid, 0);
    check("R8 code", msgCode, 0);
    check("R8 syncErr", syncErrPulse, 0);
    check("R8 invalid", invalidPulse, 0);
  endtask

  task automatic testValidEntry();
    rxEnable = 1'b1; invIntEnable = 1'b1;
    for (int i = 0; i < 6; i++) sendFrame(CODE_A);
    settle();
    check("R2 six matches not valid", msgValid, 0);
    check("R1 code extracted", msgCode, CODE_A);
    sendFrame(CODE_A); settle();
    check("R2 seventh match valid", msgValid, 1);
    check("R5 no sync error on frames", syncCnt, 0);
  endtask

  task automatic testDropOut();
    for (int i = 0; i < 3; i++) sendFrame(CODE_B);
    settle();
    check("R3 7 of 10 keeps valid", msgValid, 1);
    check("R3 code held", msgCode, CODE_A);
    check("R4 no pulse yet", invCnt, 0);
    sendFrame(CODE_B); settle();
    check("R3 6 of 10 drops valid", msgValid, 0);
    check("R4 invalid pulse", invCnt, 1);
  endtask

  task automatic testReplace();
    sendFrame(CODE_B); settle();
    check("R6 candidate replaced", msgCode, CODE_B);
    for (int i = 0; i < 5; i++) sendFrame(CODE_B);
    settle();
    check("R6 history restarted", msgValid, 0);
    sendFrame(CODE_B); settle();
    check("R6 new code valid", msgValid, 1);
    check("R6 new code value", msgCode, CODE_B);
  endtask

  task automatic testMaskedInt();
    invIntEnable = 1'b0;
    for (int i = 0; i < 4; i++) sendFrame(CODE_A);
    settle();
    check("R4 masked drop valid", msgValid, 0);
    check("R4 masked no pulse", invCnt, 1);
    invIntEnable = 1'b1;
  endtask

  task automatic testDisable();
    for (int i = 0; i < 7; i++) sendFrame(CODE_A);
    for (int i = 0; i < 3; i++) sendFrame(CODE_B);
    settle();
    check("R7 precondition valid", msgValid, 1);
    // breaking frame, last bit strobed as enable drops
    for (int i = 0; i < 8; i++) sendBit(1'b1);
    sendBit(1'b0);
    for (int i = 5; i >= 0; i--) sendBit(CODE_B[i]);
    @(negedge clk);
    rxEnable = 1'b0; bitIn = 1'b0; bitStrobe = 1'b1;
    @(negedge clk);
    bitStrobe = 1'b0;
    for (int i = 0; i < 40; i++) sendBit(1'b0);
    settle();
    check("R7 valid cleared", msgValid, 0);
    check("R7 code cleared", msgCode, 0);
    check("R7 no invalid pulse", invCnt, 1);
    check("R7 no sync pulse", syncCnt, 0);
    rxEnable = 1'b1;
    for (int i = 0; i < 6; i++) sendFrame(CODE_A);
    settle();
    check("R7 history cleared", msgValid, 0);
  endtask

  task automatic testSync();
    int base;
    clearRx();
    base = syncCnt;
    for (int i = 0; i < 31; i++) sendBit(1'b0);
    settle();
    check("R5 31 bits no error", syncCnt, base);
    sendBit(1'b0); settle();
    check("R5 32nd bit error", syncCnt, base + 1);
    for (int i = 0; i < 8; i++) sendBit(1'b1);
    for (int i = 0; i < 31; i++) sendBit(1'b0);
    settle();
    check("R5 ones restart window", syncCnt, base + 1);
    sendBit(1'b0); settle();
    check("R5 error after restart", syncCnt, base + 2);
    clearRx();
    for (int i = 0; i < 31; i++) sendBit(1'b0);
    @(negedge clk);
    rxEnable = 1'b0; bitIn = 1'b0; bitStrobe = 1'b1;
    @(negedge clk);
    bitStrobe = 1'b0; rxEnable = 1'b1;
    sendBit(1'b0); settle();
    check("R7 disable beats sync error", syncCnt, base + 2);
  endtask

  task automatic testNoStrobe();
    int base;
    clearRx();
    base = syncCnt;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); bitIn = i[0];
    end
    settle();
    check("R9 no strobe no error", syncCnt, base);
    check("R9 no strobe no valid", msgValid, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rxEnable = 1'b0; invIntEnable = 1'b0;
    bitIn = 1'b0; bitStrobe = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testValidEntry();
    testDropOut();
    testReplace();
    testMaskedInt();
    testDisable();
    testSync();
    testNoStrobe();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule